// File: doc/BRIEF.md
# GPIO Controller with Routed Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 lines. It has a single-cycle 32-bit register port. The port takes a byte address, a write enable and write data, and it returns read data combinationally. Each line has an output latch and a direction bit that decide what the line drives. Each line also has an input sample, normally taken through a two-stage synchronizer. A per-line bypass bit can select the raw pin instead.

Every line can raise an interrupt. It has its own mask bit and a trigger mode built from a polarity bit and an edge bit: low level, high level, falling edge or rising edge. A per-line 8-bit routing field sends the condition to one of a small number of shared interrupt outputs. Several lines may share one output, and that output is the OR of their conditions. A routing value at or above the number of outputs sends the line nowhere.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq_out` is 0. The line count `LINES` (1 to 32) defaults to 32.
- R2: The input word at offset 0x00 shows a pin change exactly two clock edges after it, when the line's bypass bit is clear. Writes to 0x00 have no effect.
- R3: When a line's bit in the bypass register (0x18) is set, the input word and the interrupt logic use the raw pin with no clock delay.
- R4: Output latch (0x04) and direction (0x08): `pin_oe` equals the direction register, and `pin_out` is the output latch ANDed with the direction bits.
- R5: With edge bit (0x14) clear, polarity bit (0x10) 0 asserts the interrupt while the sampled input is 0, and polarity 1 asserts it while the sampled input is 1. The interrupt stays asserted for as long as the level holds.
- R6: With edge bit set, polarity 1 triggers on a 0-to-1 change and polarity 0 on a 1-to-0 change of the sampled input. Each trigger is a pulse exactly one clock long. The opposite change produces nothing.
- R7: A line whose bit in the mask register (0x0C) is 0 never asserts any interrupt output. Clearing a mask bit removes a held level interrupt at once.
- R8: The routing field of line i is bits [8*(i%4)+7 : 8*(i%4)] of the word at 0x20 + 4*(i/4). Output k is the OR of all unmasked, triggering lines whose field equals k. A field value at or above `IRQ_OUTS` routes the line to no output.
- R9: Bits for lines at or above `LINES` read 0 and ignore writes, including routing bytes. Unused offsets and addresses not aligned to a word read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | LINES | Line input levels from the pads |
| pin_out | output | LINES | Line output values |
| pin_oe | output | LINES | Line output enables (1 = drive) |
| irq_out | output | IRQ_OUTS | Shared interrupt outputs |

## Verification
The hardest case to reach from the ports is a single edge pulse on the right shared output, at the right clock. That needs a quiet history in the synchronizer and the edge register before the mask is opened. Otherwise a stale edge leaks out and hides errors in mode or routing. The bench therefore first parks each line at its idle level with the mask closed and waits for the pipeline to settle. Only then does it unmask the line and toggle it. It sweeps every line, every trigger mode and every output index, and samples the outputs one, two and three edges after the change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word indices (byte offset / 4) of the register file
  localparam int WD_DATA = 0;
  localparam int WD_OUT  = 1;
  localparam int WD_DIR  = 2;
  localparam int WD_MASK = 3;
  localparam int WD_POL  = 4;
  localparam int WD_EDGE = 5;
  localparam int WD_BYP  = 6;
  localparam int WD_MAP  = 8;

  localparam int FIELD_W = 8;   // routing field width
  localparam int PER_WORD = 32 / FIELD_W;

  // Word index holding the routing field of a given line
  function automatic int map_word(input int line);
    return WD_MAP + line / PER_WORD;
  endfunction

  // Least significant bit of a line's routing field inside its word
  function automatic int map_lsb(input int line);
    return (line % PER_WORD) * FIELD_W;
  endfunction

  // Trigger condition from mode bits, current and previous sample
  function automatic logic line_hit(input logic pol, input logic edg,
                                    input logic cur, input logic prev);
    if (edg)
      return pol ? (cur & ~prev) : (~cur & prev);
    else
      return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] byp,
  output logic [N-1:0] smp
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= raw;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign smp = (byp & raw) | (~byp & stg[STAGES-1]);

endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] edg,
  input  logic [N-1:0] mask,
  output logic [N-1:0] hit
);
  import gpio_irq_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign hit[i] = mask[i] & line_hit(pol[i], edg[i], smp[i], prev_q[i]);
  end

  // An edge-mode trigger never lasts two consecutive cycles (R6)
  assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((edg & hit) != '0) |=> ((edg & hit & $past(edg & hit)) == '0));

endmodule

// File: rtl/gpio_route.sv
module gpio_route #(
  parameter int N    = 32,
  parameter int OUTS = 4,
  parameter int FW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hit,
  input  logic [N*FW-1:0] map,
  output logic [OUTS-1:0] irq
);
  always_comb begin
    irq = '0;
    for (int k = 0; k < OUTS; k++)
      for (int i = 0; i < N; i++)
        if (map[i*FW +: FW] == FW'(k)) irq[k] = irq[k] | hit[i];
  end

  // No routed output without a triggering line (R8)
  assert_route_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (irq == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int LINES    = 32,
  parameter int IRQ_OUTS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [LINES-1:0]    pin_in,
  output logic [LINES-1:0]    pin_out,
  output logic [LINES-1:0]    pin_oe,
  output logic [IRQ_OUTS-1:0] irq_out
);
  import gpio_irq_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam int FW     = FIELD_W;
  localparam logic [WORD_W-1:0] W_DATA = WORD_W'(WD_DATA);
  localparam logic [WORD_W-1:0] W_OUT  = WORD_W'(WD_OUT);
  localparam logic [WORD_W-1:0] W_DIR  = WORD_W'(WD_DIR);
  localparam logic [WORD_W-1:0] W_MASK = WORD_W'(WD_MASK);
  localparam logic [WORD_W-1:0] W_POL  = WORD_W'(WD_POL);
  localparam logic [WORD_W-1:0] W_EDGE = WORD_W'(WD_EDGE);
  localparam logic [WORD_W-1:0] W_BYP  = WORD_W'(WD_BYP);
  localparam logic [WORD_W-1:0] W_MAP  = WORD_W'(WD_MAP);

  logic [WORD_W-1:0]   word;
  logic                aligned;
  logic [LINES-1:0]    out_q, dir_q, mask_q, pol_q, edge_q, byp_q;
  logic [LINES*FW-1:0] map_q;
  logic [LINES-1:0]    smp;
  logic [LINES-1:0]    hit;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      byp_q  <= '0;
      map_q  <= '0;
    end else if (bus_we && aligned) begin
      case (word)
        W_OUT:  out_q  <= bus_wdata[LINES-1:0];
        W_DIR:  dir_q  <= bus_wdata[LINES-1:0];
        W_MASK: mask_q <= bus_wdata[LINES-1:0];
        W_POL:  pol_q  <= bus_wdata[LINES-1:0];
        W_EDGE: edge_q <= bus_wdata[LINES-1:0];
        W_BYP:  byp_q  <= bus_wdata[LINES-1:0];
        default: ;
      endcase
      for (int ln = 0; ln < LINES; ln++)
        if (int'(word) == map_word(ln))
          map_q[ln*FW +: FW] <= bus_wdata[map_lsb(ln) +: FW];
    end
  end

  // Register reads
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        W_DATA: bus_rdata[LINES-1:0] = smp;
        W_OUT:  bus_rdata[LINES-1:0] = out_q;
        W_DIR:  bus_rdata[LINES-1:0] = dir_q;
        W_MASK: bus_rdata[LINES-1:0] = mask_q;
        W_POL:  bus_rdata[LINES-1:0] = pol_q;
        W_EDGE: bus_rdata[LINES-1:0] = edge_q;
        W_BYP:  bus_rdata[LINES-1:0] = byp_q;
        default: ;
      endcase
      for (int ln = 0; ln < LINES; ln++)
        if (int'(word) == map_word(ln))
          bus_rdata[map_lsb(ln) +: FW] = map_q[ln*FW +: FW];
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;

  gpio_sync #(.N(LINES), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pin_in),
    .byp  (byp_q),
    .smp  (smp)
  );

  gpio_trig #(.N(LINES)) u_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .smp  (smp),
    .pol  (pol_q),
    .edg  (edge_q),
    .mask (mask_q),
    .hit  (hit)
  );

  gpio_route #(.N(LINES), .OUTS(IRQ_OUTS), .FW(FW)) u_route (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (hit),
    .map  (map_q),
    .irq  (irq_out)
  );

  // A direction write shows on the enables one edge later (R4)
  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && aligned && word == W_DIR) |=> (pin_oe == $past(bus_wdata[LINES-1:0])));

  // All lines masked: every shared output is quiet (R7)
  assert_mask_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (irq_out == '0));

  if (LINES < 32) begin : g_upper
    // Bits above the line count read as zero (R9)
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (word < W_MAP) |-> (bus_rdata[31:LINES] == '0));
  end

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;
  localparam int NO = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic [NO-1:0] irq_out;

  int errs = 0;
  int checks = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.LINES(NL), .IRQ_OUTS(NO), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [NL-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    for (int a = 0; a < 11; a++) begin
      rd(8'(a*4), rv);
      chk($sformatf("R1 reg 0x%0h", a*4), rv, 32'h0);
    end
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 pin_out", 32'(pin_out), 32'h0);
    chk("R1 irq_out", 32'(irq_out), 32'h0);

    // R4 and R9: output latch and direction
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_002A);
    chk("R4 pin_oe", 32'(pin_oe), 32'h2A);
    chk("R4 pin_out", 32'(pin_out), 32'h2A);
    rd(8'h04, rv); chk("R9 out high bits", rv, 32'h3F);
    rd(8'h08, rv); chk("R4 dir readback", rv, 32'h2A);
    wr(8'h08, 32'h0000_0001);
    chk("R4 pin_out gated", 32'(pin_out), 32'h01);

    // R2: two-edge synchronizer, data not writable
    drive(6'h15);
    step(1); rd(8'h00, rv); chk("R2 one edge", rv, 32'h0);
    step(1); rd(8'h00, rv); chk("R2 two edges", rv, 32'h15);
    wr(8'h00, 32'h3F);
    rd(8'h00, rv); chk("R2 write ignored", rv, 32'h15);

    // R3: bypass
    wr(8'h18, 32'h3F);
    drive(6'h0A); #1;
    rd(8'h00, rv); chk("R3 raw data", rv, 32'h0A);
    drive(6'h00);
    wr(8'h10, 32'h01); wr(8'h14, 32'h01);
    wr(8'h20, 32'hFFFF_FF01); wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h01);
    drive(6'h01); #1;
    chk("R3 raw edge pulse", 32'(irq_out), 32'h2);
    step(1);
    chk("R3 pulse ends", 32'(irq_out), 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'h0);
    drive(6'h00); step(3);

    // R5/R6/R8 sweep: every line, mode and output
    for (int ln = 0; ln < NL; ln++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int k = 0; k < NO; k++) begin
          logic pol, edg;
          logic [31:0] m0, m1;
          logic [NL-1:0] idle_v, act_v;
          string tag;
          pol = mode[0]; edg = mode[1];
          tag = $sformatf("%s R8 line%0d mode%0d out%0d", edg ? "R6" : "R5", ln, mode, k);
          wr(8'h0C, 32'h0);
          wr(8'h10, 32'(pol) << ln);
          wr(8'h14, 32'(edg) << ln);
          m0 = 32'hFFFF_FFFF; m1 = 32'hFFFF_FFFF;
          if (ln < 4) m0[8*ln +: 8] = 8'(k);
          else        m1[8*(ln-4) +: 8] = 8'(k);
          wr(8'h20, m0); wr(8'h24, m1);
          idle_v = pol ? '0 : NL'(1) << ln;
          act_v  = pol ? NL'(1) << ln : '0;
          drive(idle_v); step(3);
          wr(8'h0C, 32'(1) << ln);
          chk({tag, " quiet"}, 32'(irq_out), 32'h0);
          drive(act_v);
          step(1); chk({tag, " before sync"}, 32'(irq_out), 32'h0);
          step(1); chk({tag, " trigger"}, 32'(irq_out), 32'(1) << k);
          step(1); chk({tag, " next"}, 32'(irq_out), edg ? 32'h0 : 32'(1) << k);
          drive(idle_v);
          step(2); chk({tag, " release"}, 32'(irq_out), 32'h0);
        end
      end
    end

    // R8: out-of-range index and shared outputs; R7: mask removal
    wr(8'h0C, 32'h0);
    drive(6'h00); step(3);
    wr(8'h10, 32'h3F); wr(8'h14, 32'h0);
    wr(8'h20, 32'h0300_0202);
    wr(8'h0C, 32'h0F);
    drive(6'h08); step(2); chk("R8 index out of range", 32'(irq_out), 32'h0);
    drive(6'h02); step(2); chk("R8 line1 to out2", 32'(irq_out), 32'h4);
    drive(6'h03); step(2); chk("R8 two lines share out2", 32'(irq_out), 32'h4);
    drive(6'h07); step(2); chk("R8 out2 and out0", 32'(irq_out), 32'h5);
    drive(6'h04); step(2); chk("R8 line2 to out0", 32'(irq_out), 32'h1);
    wr(8'h0C, 32'h0B);
    chk("R7 mask clears level", 32'(irq_out), 32'h0);
    wr(8'h0C, 32'h0);

    // R9: unimplemented bits and offsets
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, rv); chk("R9 map bytes beyond lines", rv, 32'h0000_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, rv); chk("R9 map word beyond lines", rv, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, rv); chk("R9 gap offset", rv, 32'h0);
    wr(8'h16, 32'h0);
    rd(8'h14, rv); chk("R9 misaligned write ignored", rv, 32'h0);
    rd(8'h11, rv); chk("R9 misaligned read", rv, 32'h0);
    rd(8'h10, rv); chk("R9 pol high bits", rv, 32'h3F);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule